// File: doc/BRIEF.md
# Multi-scale sub-window scanner

This block walks every detection window of a fixed 320x240 grayscale frame across a ladder of window sizes. It feeds the first classifier stage of a boosted detector cascade, which has to look at every window of the frame. Each window comes out as a 32-bit address word and the window's edge length in pixels. The address word packs the window's top-left position as a row-major linear index and adds a scale code.

One pulse on the frame-start input begins a scan. Scale 0 is scanned first. Within a scale, rows go from top to bottom and columns from left to right. The shift between neighbouring windows grows with the scale. Each window sits on a valid/ready handshake and waits there until it is taken. A flag marks the final window of the frame. After that window is taken, the block stays idle until the next frame-start pulse.

The window size and the shift step of each scale come from a fixed-point ladder that is evaluated at elaboration. The run-time datapath therefore has only adders and comparators.

Top module: `subwin_scanner`

## Requirements
- R1: While reset is asserted, and after it is released until the first frame-start pulse, `valid_o` and `last_o` are low.
- R2: A `start_i` pulse while the block is idle makes `valid_o` high on the next clock edge. The first window has address word 0 and size 24.
- R3: Windows come out in this order: scale code ascending; within a scale, row ascending; within a row, column ascending. Each window in the sequence is the immediate successor of the one before it.
- R4: Scale s (0 to 10) has a window size of round(24·1.25^s) and a shift step of round(1.5·1.25^s). Halves round up. The sizes are 24,30,38,47,59,73,92,114,143,179,224 and the steps are 2,2,2,3,4,5,6,7,9,11,14. `win_size_o` gives the size of the scale being output.
- R5: Column positions within a row are 0, step, 2·step, and so on, up to the largest one with column+size ≤ 320. Row positions are built the same way against 240. No emitted window extends past the frame.
- R6: In the address word, bits [16:0] hold row·320+column, bits [20:17] hold the scale code and bits [31:21] are zero.
- R7: While `valid_o` is high and `ready_i` is low, `valid_o`, `addr_o`, `win_size_o` and `last_o` keep their values into the next cycle.
- R8: `last_o` is high exactly on the last window of scale 10. Once that window is accepted, `valid_o` goes low and stays low until a new `start_i` pulse.
- R9: A `start_i` pulse during a scan has no effect, and the sequence carries on unchanged.
- R10: One scan gives exactly the number of windows that R4 and R5 imply, summed over all 11 scales.
- R11: While `ready_i` is held high, one window is accepted on every cycle from the first window to the last, with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame-start pulse; only acts when the block is idle |
| ready_i | input | 1 | Consumer accepts the current window |
| valid_o | output | 1 | A window is being presented |
| addr_o | output | 32 | Packed word: linear position [16:0], scale code [20:17], zero above |
| win_size_o | output | 8 | Edge length of the current window in pixels |
| last_o | output | 1 | Current window is the final one of the frame |

## Verification
The assertions check several properties on every cycle. Every presented window lies inside the frame. Each axis's linear base agrees with its position. The scale code never goes down while a scan is running. A stalled window holds still. The scan continues without a bubble until the last window, and valid drops right after that window is taken.

Other properties can only be shown by the bench's scenarios. These are the exact window sequence for each scale, the rounded size and step values, the total window count, the position of the last flag, and the fact that a start pulse during a scan is ignored. The bench compares a full frame window by window under a periodic stall pattern, and a second full frame with ready held high.

// File: rtl/subwin_pkg.sv
package subwin_pkg;
  localparam int FRAME_W      = 320;
  localparam int FRAME_H      = 240;
  localparam int BASE_WIN     = 24;
  localparam int NUM_SCALES   = 11;
  localparam int FRAC_BITS    = 8;
  localparam int BASE_STEP_FX = 384;  // 1.5 in Q8
  localparam int ADDR_W       = 32;

  localparam int X_W    = $clog2(FRAME_W);
  localparam int Y_W    = $clog2(FRAME_H);
  localparam int LIN_W  = $clog2(FRAME_W * FRAME_H);
  localparam int SCL_W  = $clog2(NUM_SCALES);
  localparam int SIZE_W = $clog2(FRAME_H + 1);

  // ratio 5/4 applied s times in fixed point
  function automatic int ladder_fx(input int base_fx, input int s);
    int v;
    v = base_fx;
    for (int i = 0; i < s; i++) v = (v * 5) / 4;
    return v;
  endfunction

  function automatic int fx_round(input int v);
    return (v + (1 << (FRAC_BITS - 1))) >>> FRAC_BITS;
  endfunction

  function automatic int scale_size(input int s);
    return fx_round(ladder_fx(BASE_WIN << FRAC_BITS, s));
  endfunction

  function automatic int scale_step(input int s);
    int r;
    r = fx_round(ladder_fx(BASE_STEP_FX, s));
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/subwin_scale_rom.sv
module subwin_scale_rom
  import subwin_pkg::*;
(
  input  logic [SCL_W-1:0]  scl_i,
  output logic [SIZE_W-1:0] size_o,
  output logic [SIZE_W-1:0] step_o
);
  logic [SIZE_W-1:0] size_tab [NUM_SCALES];
  logic [SIZE_W-1:0] step_tab [NUM_SCALES];

  for (genvar g = 0; g < NUM_SCALES; g++) begin : g_ent
    localparam int SZ = scale_size(g);
    localparam int ST = scale_step(g);
    assign size_tab[g] = SIZE_W'(SZ);
    assign step_tab[g] = SIZE_W'(ST);
  end

  always_comb begin
    size_o = size_tab[0];
    step_o = step_tab[0];
    for (int i = 0; i < NUM_SCALES; i++) begin
      if (scl_i == SCL_W'(i)) begin
        size_o = size_tab[i];
        step_o = step_tab[i];
      end
    end
  end
endmodule

// File: rtl/subwin_axis.sv
module subwin_axis
  import subwin_pkg::*;
#(
  parameter int EXTENT = 320,
  parameter int POS_W  = 9,
  parameter int BASE_W = 17,
  parameter int STRIDE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [SIZE_W-1:0] step_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [POS_W-1:0]  pos_o,
  output logic [BASE_W-1:0] base_o,
  output logic              wrap_o
);
  localparam int SUM_W = POS_W + 2;

  logic [POS_W-1:0]  pos_q;
  logic [BASE_W-1:0] base_q;

  // next window would cross the frame edge
  assign wrap_o = (SUM_W'(pos_q) + SUM_W'(step_i) + SUM_W'(size_i)) > SUM_W'(EXTENT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      base_q <= '0;
    end else if (clr_i || (adv_i && wrap_o)) begin
      pos_q  <= '0;
      base_q <= '0;
    end else if (adv_i) begin
      pos_q  <= pos_q + POS_W'(step_i);
      base_q <= base_q + BASE_W'(step_i) * BASE_W'(STRIDE);
    end
  end

  assign pos_o  = pos_q;
  assign base_o = base_q;

  a_r5_pos_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    SUM_W'(pos_q) < SUM_W'(EXTENT));

  a_r6_base_tracks_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_q == BASE_W'(pos_q) * BASE_W'(STRIDE));
endmodule

// File: rtl/subwin_scanner.sv
module subwin_scanner
  import subwin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [31:0]       addr_o,
  output logic [SIZE_W-1:0] win_size_o,
  output logic              last_o
);
  localparam logic [SCL_W-1:0] LAST_SCL = SCL_W'(NUM_SCALES - 1);
  localparam int PAD_W = ADDR_W - SCL_W - LIN_W;

  logic             run_q;
  logic [SCL_W-1:0] scl_q;
  logic [SIZE_W-1:0] size_w, step_w;
  logic [X_W-1:0]   x_pos;
  logic [Y_W-1:0]   y_pos;
  logic [LIN_W-1:0] x_base, y_base;
  logic             x_wrap, y_wrap;
  logic             go, fire, scl_done;

  assign go       = start_i && !run_q;
  assign fire     = run_q && ready_i;
  assign scl_done = fire && x_wrap && y_wrap;

  subwin_scale_rom u_rom (
    .scl_i  (scl_q),
    .size_o (size_w),
    .step_o (step_w)
  );

  subwin_axis #(.EXTENT(FRAME_W), .POS_W(X_W), .BASE_W(LIN_W), .STRIDE(1)) u_col (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (go),
    .adv_i  (fire),
    .step_i (step_w),
    .size_i (size_w),
    .pos_o  (x_pos),
    .base_o (x_base),
    .wrap_o (x_wrap)
  );

  subwin_axis #(.EXTENT(FRAME_H), .POS_W(Y_W), .BASE_W(LIN_W), .STRIDE(FRAME_W)) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (go),
    .adv_i  (fire && x_wrap),
    .step_i (step_w),
    .size_i (size_w),
    .pos_o  (y_pos),
    .base_o (y_base),
    .wrap_o (y_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      scl_q <= '0;
    end else if (go) begin
      run_q <= 1'b1;
      scl_q <= '0;
    end else if (scl_done) begin
      if (scl_q == LAST_SCL) begin
        run_q <= 1'b0;
        scl_q <= '0;
      end else begin
        scl_q <= scl_q + 1'b1;
      end
    end
  end

  assign valid_o    = run_q;
  assign addr_o     = {{PAD_W{1'b0}}, scl_q, y_base + x_base};
  assign win_size_o = size_w;
  assign last_o     = run_q && (scl_q == LAST_SCL) && x_wrap && y_wrap;

  a_r5_window_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((11'(x_pos) + 11'(size_w)) <= 11'(FRAME_W)) &&
                ((11'(y_pos) + 11'(size_w)) <= 11'(FRAME_H)));

  a_r7_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(win_size_o) && $stable(last_o)));

  a_r8_last_ends_scan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && last_o) |=> !valid_o);

  a_r11_no_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !last_o) |=> valid_o);

  a_r3_scale_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !last_o) |=> (scl_q >= $past(scl_q)));
endmodule

// File: tb/subwin_scanner_tb.sv
module subwin_scanner_tb_top;
  localparam int NSC = 11;
  localparam int EXP_SIZE [NSC] = '{24, 30, 38, 47, 59, 73, 92, 114, 143, 179, 224};
  localparam int EXP_STEP [NSC] = '{2, 2, 2, 3, 4, 5, 6, 7, 9, 11, 14};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        ready_i = 1'b0;
  logic        valid_o;
  logic [31:0] addr_o;
  logic [7:0]  win_size_o;
  logic        last_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  subwin_scanner dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ready_i    (ready_i),
    .valid_o    (valid_o),
    .addr_o     (addr_o),
    .win_size_o (win_size_o),
    .last_o     (last_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expected_total();
    int t = 0;
    for (int s = 0; s < NSC; s++)
      t += ((240 - EXP_SIZE[s]) / EXP_STEP[s] + 1) * ((320 - EXP_SIZE[s]) / EXP_STEP[s] + 1);
    return t;
  endfunction

  // walks the expected sequence; ready_mod>0 drops ready every ready_mod-th cycle
  task automatic run_frame(input int ready_mod, input int pulse_at, input bit strict);
    int  idx = 0;
    int  cyc = 0;
    bit  stalled = 0;
    logic [31:0] held = '0;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    chk(valid_o && addr_o == 32'd0 && win_size_o == 8'd24, "R2 first window", addr_o, 0);
    for (int s = 0; s < NSC; s++) begin
      for (int y = 0; y + EXP_SIZE[s] <= 240; y += EXP_STEP[s]) begin
        for (int x = 0; x + EXP_SIZE[s] <= 320; x += EXP_STEP[s]) begin
          bit acc = 0;
          bit is_last = (s == NSC - 1) && (y + EXP_STEP[s] + EXP_SIZE[s] > 240) &&
                        (x + EXP_STEP[s] + EXP_SIZE[s] > 320);
          logic [31:0] exp_addr = {11'd0, 4'(s), 17'(y * 320 + x)};
          while (!acc) begin
            if (cyc > 0) @(negedge clk_i);
            cyc++;
            start_i = (idx == pulse_at);
            ready_i = (ready_mod == 0) || (cyc % ready_mod != 0);
            if (!valid_o) begin
              if (strict) chk(1'b0, "R11 gap in scan", 0, 1);
            end else begin
              if (stalled) chk(addr_o == held, "R7 held during stall", addr_o, held);
              if (ready_i) begin
                chk(addr_o == exp_addr, "R3 R5 R6 R9 address order", addr_o, exp_addr);
                chk(win_size_o == 8'(EXP_SIZE[s]), "R4 window size", win_size_o, EXP_SIZE[s]);
                chk(last_o == is_last, "R8 last flag", last_o, is_last);
                acc = 1;
                stalled = 0;
                idx++;
              end else begin
                stalled = 1;
                held = addr_o;
              end
            end
          end
        end
      end
    end
    @(negedge clk_i);
    start_i = 1'b0;
    ready_i = 1'b1;
    chk(!valid_o, "R8 valid drops after last", valid_o, 0);
    chk(idx == expected_total(), "R10 window count", idx, expected_total());
    repeat (5) @(negedge clk_i);
    chk(!valid_o, "R8 stays idle without start", valid_o, 0);
  endtask

  initial begin : main
    ready_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!valid_o && !last_o, "R1 in reset", valid_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!valid_o && !last_o, "R1 idle after reset", valid_o, 0);
    run_frame(4, 5000, 1'b0);
    run_frame(0, 1234, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule